// File: doc/BRIEF.md
# Segment deinterleave unit

This unit turns array-of-structures data into one structure field. A segment load brings records of `nf` fields from memory. The fields of one record sit next to each other, and the records follow one after another. The load fills `nf` consecutive vector registers in memory order. For a chosen field index, this block takes those registers one beat at a time. It gathers every `nf`-th element, starting at that field, and packs the gathered elements densely into a single destination vector.

An operation begins with `start_i`. That cycle latches the following:
- the field count;
- the field index;
- the element size;
- the number of elements held by each source register;
- an optional per-segment mask;
- the prior destination contents.

The source registers then arrive on `src_i` with `src_valid_i`. Idle cycles between beats are allowed. After the last beat, `done_o` pulses for one cycle, and `dst_o` holds the packed result until the next start. Destination elements that are masked off, and bytes beyond the packed elements, keep the prior destination contents.

Top module: `seg_deinterleave`

## Requirements
- R1: During and directly after reset, `dst_o` is all zeros and `done_o` is low.
- R2: A `start_i` accepted while idle makes `dst_o` equal to `old_dst_i` in the following cycle. It also latches `nf_i`, `field_i`, `esz_i`, `epr_i`, `mask_en_i` and `mask_i` for the whole operation.
- R3: Number memory elements g = 0 .. `nf`·`epr`−1, where beat b carries elements b·`epr` .. b·`epr`+`epr`−1 and element g sits at position g mod `epr` of its beat. Destination element e (0 ≤ e < `epr`) then receives memory element `field` + e·`nf`. Here `nf` is 2 to 8 and `field` is less than `nf`.
- R4: `esz_i` selects the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Position p of a register occupies bytes p·size .. p·size+size−1, where byte n is bits 8n+7:8n. Each copy moves exactly that many bytes, and their order is kept.
- R5: With `mask_en_i` high, destination element e is written only when `mask_i[e]` is 1. Bit e is the segment index, so it covers all fields of record e. Otherwise the element keeps its prior value. With `mask_en_i` low, `mask_i` has no effect.
- R6: Destination bytes at or above `epr`·size keep their prior value.
- R7: Exactly `nf` beats are consumed, one per cycle with `src_valid_i` high. Any number of idle cycles may separate beats without changing the result.
- R8: `done_o` is high for exactly one cycle: the cycle after the `nf`-th beat is consumed. It is low at all other times.
- R9: `src_valid_i` while idle has no effect on `dst_o` or `done_o`. A `start_i` raised during an operation is ignored.
- R10: After `done_o`, `dst_o` keeps the result until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| nf_i | input | 4 | Field count, 2 to 8 |
| field_i | input | 3 | Field index to extract |
| esz_i | input | 2 | Element size code (1/2/4/8 bytes) |
| epr_i | input | 5 | Elements per source register |
| mask_en_i | input | 1 | Apply per-segment mask |
| mask_i | input | 16 | Mask, one bit per segment |
| old_dst_i | input | 128 | Prior destination contents |
| src_valid_i | input | 1 | Source beat valid |
| src_i | input | 128 | Source register beat |
| dst_o | output | 128 | Packed destination register |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a selected element that lands in the last source beat at the highest position. This happens with the largest field count, the largest field index and the widest element. There, the gather window and the byte-lane arithmetic both hit their upper bounds. The stimulus covers it with dedicated runs at eight fields and the last field index, at 8-byte and 1-byte elements. These runs also stall between beats and raise `start_i` in the middle of an operation. Every case is checked against a model written at the memory level, which never uses the beat-by-beat window.

// File: rtl/deint_pkg.sv
package deint_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  function automatic int esz_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/deint_ctrl.sv
module deint_ctrl #(
  parameter  int MAX_NF = 8,
  localparam int NF_W   = $clog2(MAX_NF) + 1,
  localparam int IDX_W  = $clog2(MAX_NF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             src_valid_i,
  input  logic [NF_W-1:0]  nf_i,
  output logic             busy_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] cnt_q;
  logic             last_beat;

  assign wr_o      = busy_q & src_valid_i;
  assign last_beat = ({1'b0, cnt_q} == nf_i - NF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (src_valid_i) begin
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = cnt_q;
  assign done_o = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_q) && $past(src_valid_i)));

  // R7
  beat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ({1'b0, cnt_q} < nf_i));
endmodule

// File: rtl/deint_gather.sv
module deint_gather #(
  parameter  int VLEN_BYTES = 16,
  parameter  int MAX_NF     = 8,
  localparam int VLEN       = VLEN_BYTES * 8,
  localparam int NF_W       = $clog2(MAX_NF) + 1,
  localparam int IDX_W      = $clog2(MAX_NF),
  localparam int EPR_W      = $clog2(VLEN_BYTES) + 1
) (
  input  logic [VLEN-1:0]       acc_i,
  input  logic [VLEN-1:0]       src_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NF_W-1:0]       nf_i,
  input  logic [IDX_W-1:0]      field_i,
  input  logic [1:0]            esz_i,
  input  logic [EPR_W-1:0]      epr_i,
  input  logic                  mask_en_i,
  input  logic [VLEN_BYTES-1:0] mask_i,
  output logic [VLEN-1:0]       nxt_o
);
  import deint_pkg::*;

  int g, lo, p, eb, ep;

  // Each destination slot looks up whether its source element lies in this beat.
  always_comb begin
    nxt_o = acc_i;
    eb    = esz_bytes(esz_i);
    ep    = int'(epr_i);
    lo    = int'(idx_i) * ep;
    for (int e = 0; e < VLEN_BYTES; e++) begin
      g = int'(field_i) + e * int'(nf_i);
      p = g - lo;
      if (e < ep && p >= 0 && p < ep && (!mask_en_i || mask_i[e])) begin
        for (int k = 0; k < 8; k++) begin
          if (k < eb && (e * eb + k) < VLEN_BYTES && (p * eb + k) < VLEN_BYTES)
            nxt_o[(e*eb+k)*8 +: 8] = src_i[(p*eb+k)*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/seg_deinterleave.sv
module seg_deinterleave #(
  parameter  int VLEN_BYTES = 16,
  parameter  int MAX_NF     = 8,
  localparam int VLEN       = VLEN_BYTES * 8,
  localparam int NF_W       = $clog2(MAX_NF) + 1,
  localparam int IDX_W      = $clog2(MAX_NF),
  localparam int EPR_W      = $clog2(VLEN_BYTES) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NF_W-1:0]       nf_i,
  input  logic [IDX_W-1:0]      field_i,
  input  logic [1:0]            esz_i,
  input  logic [EPR_W-1:0]      epr_i,
  input  logic                  mask_en_i,
  input  logic [VLEN_BYTES-1:0] mask_i,
  input  logic [VLEN-1:0]       old_dst_i,
  input  logic                  src_valid_i,
  input  logic [VLEN-1:0]       src_i,
  output logic [VLEN-1:0]       dst_o,
  output logic                  done_o
);
  logic                  busy, wr;
  logic [IDX_W-1:0]      idx;
  logic [NF_W-1:0]       nf_q;
  logic [IDX_W-1:0]      field_q;
  logic [1:0]            esz_q;
  logic [EPR_W-1:0]      epr_q;
  logic                  men_q;
  logic [VLEN_BYTES-1:0] mask_q;
  logic [VLEN-1:0]       dst_q, dst_nxt;
  logic                  accept;

  assign accept = start_i & ~busy;

  deint_ctrl #(.MAX_NF(MAX_NF)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .src_valid_i (src_valid_i),
    .nf_i        (nf_q),
    .busy_o      (busy),
    .wr_o        (wr),
    .idx_o       (idx),
    .done_o      (done_o)
  );

  deint_gather #(.VLEN_BYTES(VLEN_BYTES), .MAX_NF(MAX_NF)) i_gather (
    .acc_i     (dst_q),
    .src_i     (src_i),
    .idx_i     (idx),
    .nf_i      (nf_q),
    .field_i   (field_q),
    .esz_i     (esz_q),
    .epr_i     (epr_q),
    .mask_en_i (men_q),
    .mask_i    (mask_q),
    .nxt_o     (dst_nxt)
  );

  // Config is latched at accept, so it is stable while the control block counts beats.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nf_q    <= NF_W'(2);
      field_q <= '0;
      esz_q   <= '0;
      epr_q   <= '0;
      men_q   <= 1'b0;
      mask_q  <= '0;
      dst_q   <= '0;
    end else if (accept) begin
      nf_q    <= nf_i;
      field_q <= field_i;
      esz_q   <= esz_i;
      epr_q   <= epr_i;
      men_q   <= mask_en_i;
      mask_q  <= mask_i;
      dst_q   <= old_dst_i;
    end else if (wr) begin
      dst_q   <= dst_nxt;
    end
  end

  assign dst_o = dst_q;

  // R2
  load_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (dst_o == $past(old_dst_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(dst_o));

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(nf_q) && $stable(field_q) && $stable(epr_q)));
endmodule

// File: tb/test_seg_deinterleave.sv
module test_seg_deinterleave;
  localparam int VB = 16;
  localparam int VW = VB * 8;
  localparam int EW = $clog2(VB) + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    nf_i = 4'd2;
  logic [2:0]    field_i = '0;
  logic [1:0]    esz_i = '0;
  logic [EW-1:0] epr_i = '0;
  logic          mask_en_i = 1'b0;
  logic [VB-1:0] mask_i = '0;
  logic [VW-1:0] old_dst_i = '0;
  logic          src_valid_i = 1'b0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] dst_o;
  logic          done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_deinterleave i_seg_deinterleave (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Expected result is computed at the memory level: element field+e*nf.
  task automatic run_op(input int nf, input int field, input int esz, input int epr,
                        input bit men, input logic [VB-1:0] msk, input int gap,
                        input bit poke, input string req);
    logic [7:0]    mem[128];
    logic [VW-1:0] src[8];
    logic [VW-1:0] old, exp;
    int esb;
    esb = 1 << esz;
    for (int j = 0; j < 128; j++) mem[j] = 8'(j * 29 + nf * 7 + field * 3 + esz + 1);
    old = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < nf; i++) begin
      for (int b = 0; b < VB; b++)
        src[i][b*8 +: 8] = (b < epr * esb) ? mem[i * epr * esb + b] : 8'hEE;
    end
    exp = old;
    for (int e = 0; e < epr; e++) begin
      if (!men || msk[e]) begin
        for (int k = 0; k < esb; k++)
          exp[(e*esb+k)*8 +: 8] = mem[(field + e * nf) * esb + k];
      end
    end
    @(negedge clk_i);
    start_i = 1'b1; nf_i = 4'(nf); field_i = 3'(field); esz_i = 2'(esz);
    epr_i = EW'(epr); mask_en_i = men; mask_i = msk; old_dst_i = old;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(dst_o == old, "R2", "dst after start", dst_o, old);
    for (int i = 0; i < nf; i++) begin
      src_valid_i = 1'b1;
      src_i = src[i];
      if (poke && i == 1) begin
        start_i = 1'b1; old_dst_i = '1; nf_i = 4'd2; field_i = 3'd1;  // R9
      end
      @(negedge clk_i);
      src_valid_i = 1'b0;
      start_i = 1'b0;
      if (i < nf - 1)
        chk(done_o == 1'b0, "R8", "done early", VW'(done_o), VW'(0));
      for (int s = 0; s < gap && i < nf - 1; s++) begin
        @(negedge clk_i);
        chk(done_o == 1'b0, "R7", "done in gap", VW'(done_o), VW'(0));
      end
    end
    chk(done_o == 1'b1, "R8", "done pulse", VW'(done_o), VW'(1));
    chk(dst_o == exp, req, "packed result", dst_o, exp);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8", "done width", VW'(done_o), VW'(0));
    chk(dst_o == exp, "R10", "result held", dst_o, exp);
  endtask

  task automatic idle_beats();
    logic [VW-1:0] keep;
    keep = dst_o;
    @(negedge clk_i);
    src_valid_i = 1'b1;
    src_i = {VB{8'hA5}};
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      chk(dst_o == keep, "R9", "idle beat", dst_o, keep);
      chk(done_o == 1'b0, "R9", "idle done", VW'(done_o), VW'(0));
    end
    src_valid_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(dst_o == '0, "R1", "dst in reset", dst_o, '0);
    chk(done_o == 1'b0, "R1", "done in reset", VW'(done_o), VW'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dst_o == '0, "R1", "dst after reset", dst_o, '0);
    chk(done_o == 1'b0, "R1", "done after reset", VW'(done_o), VW'(0));
    run_op(2, 0, 0, 16, 1'b0, '0, 0, 1'b0, "R3");
    run_op(3, 2, 1, 8, 1'b0, '0, 0, 1'b0, "R4");
    run_op(8, 7, 3, 2, 1'b0, '0, 1, 1'b0, "R3");
    run_op(4, 1, 2, 4, 1'b1, 16'b1010, 0, 1'b0, "R5");
    run_op(5, 3, 1, 8, 1'b0, 16'h0055, 0, 1'b0, "R5");
    run_op(2, 1, 0, 5, 1'b0, '0, 0, 1'b0, "R6");
    run_op(3, 0, 2, 3, 1'b1, 16'b101, 2, 1'b0, "R6");
    run_op(6, 4, 0, 16, 1'b0, '0, 3, 1'b0, "R7");
    run_op(8, 7, 0, 16, 1'b1, 16'hC3A5, 1, 1'b1, "R9");
    idle_beats();
    run_op(7, 6, 3, 2, 1'b0, '0, 0, 1'b1, "R4");
    summary();
  end
endmodule